// File: doc/BRIEF.md
# JTAG Identification Word Reader

This block is a master-side sequencer for a single JTAG target. A one-cycle start request makes it generate a test clock and a mode-select stream that drive the target's TAP into Test-Logic-Reset and then into Shift-DR. It collects 32 bits from the target's data output, least significant first, and parks the TAP in Run-Test/Idle. No instruction is ever loaded. The engine relies on the data register that a TAP selects by default after reset. It classifies the result from the first bit it captured: a 1 means the target presented an identification word, and a 0 means the target fell back to its one-bit bypass register.

The test clock is the system clock divided by 2×(div+1). The divide value is taken at the moment a start request is accepted. Mode-select changes are made only while the test clock is low, so each change lands after a falling edge. The target's data output is sampled at the instant the test clock rises. The data input to the target carries no information and is held at logic 1.

The engine's states are named after the TAP state they track. In order they are IDLE, FORCE_RST, TLR, RTI, SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, UPDATE_DR and PARK.
- IDLE moves to FORCE_RST on start.
- FORCE_RST moves to TLR after five rising edges with mode-select high.
- TLR, RTI, SEL_DR, CAP_DR, EXIT1_DR and UPDATE_DR each move on one rising edge, to RTI, SEL_DR, CAP_DR, SHIFT_DR, UPDATE_DR and PARK respectively.
- SHIFT_DR moves to EXIT1_DR on its 32nd rising edge.
- PARK returns to IDLE on the next falling edge and raises done.

Top module: `jtag_id_reader`

## Requirements
- R1: After reset, busy, done, tck, idcode_valid and id_word are all 0, and tms is 1.
- R2: A start request in IDLE sets busy on the next clock. The first five rising tck edges of the run carry tms=1, which forces Test-Logic-Reset from any TAP state.
- R3: Each run has exactly 43 rising tck edges. Their tms values, in order, are five 1s, then 0,1,0,0, then 31 zeros and a 1 (the 32 shift edges), then 1,0. This leaves the target in Run-Test/Idle.
- R4: tms changes only while tck is low. tdo is sampled on each of the 32 rising edges that the target spends in Shift-DR.
- R5: tck is low whenever busy is low. Each tck level lasts div+1 system clocks. The div value is sampled when start is accepted, and later changes to div do not affect the run.
- R6: id_word holds the 32 sampled bits, with the first sampled bit in bit 0 and the last in bit 31. It changes only when done is raised.
- R7: idcode_valid equals the first sampled bit: 1 for an identification word, 0 for a bypass register. For a bypass target with tdi held high, id_word is 32'hFFFFFFFE.
- R8: done is a single-cycle pulse, raised 86×(div+1) clocks after the clock edge that accepted start. busy falls in that same cycle.
- R9: A start request while busy is ignored. It neither restarts, nor extends, nor queues a run.
- R10: tdi is 1 at every rising tck edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an acquisition |
| div | input | 8 | Test clock divide value; each tck level lasts div+1 clocks |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| id_word | output | 32 | Captured word, first bit in bit 0 |
| idcode_valid | output | 1 | First captured bit; 1 means an identification word is present |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target, held at 1 |
| tdo | input | 1 | Test data from the target |

## Verification
Results fall due a known number of cycles after start. busy is due on the clock after start. done, id_word and idcode_valid all fall due exactly 86×(div+1) clocks after the accepting edge. tck levels each last div+1 clocks.

The bench drives inputs and samples outputs on the falling system-clock edge. It counts clocks from the accepting edge and checks that done appears on exactly the expected count. It checks the result ports in that cycle and confirms on the following cycle that done has dropped. Per-edge tms values and the spacing between tck rises are logged by a target model at the rising tck edges, and are compared with the expected sequence once done has been seen.

// File: rtl/jid_pkg.sv
package jid_pkg;

    // Tracked TAP position of the attached target, plus engine idle.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FORCE_RST,
        ST_TLR,
        ST_RTI,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_UPDATE_DR,
        ST_PARK
    } walk_state_t;

    // Mode-select level presented for the next rising edge while the
    // target sits in the tracked state.
    function automatic logic tms_for(input walk_state_t st, input logic last_bit);
        logic v;
        v = 1'b0;
        unique case (st)
            ST_IDLE:      v = 1'b1;
            ST_FORCE_RST: v = 1'b1;
            ST_TLR:       v = 1'b0;
            ST_RTI:       v = 1'b1;
            ST_SEL_DR:    v = 1'b0;
            ST_CAP_DR:    v = 1'b0;
            ST_SHIFT_DR:  v = last_bit;
            ST_EXIT1_DR:  v = 1'b1;
            ST_UPDATE_DR: v = 1'b0;
            ST_PARK:      v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/jid_tck_gen.sv
module jid_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tck,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] phase_cnt;
    logic             terminal;

    assign terminal = run && (phase_cnt == div_val);
    assign rise_evt = terminal && !tck;
    assign fall_evt = terminal && tck;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            tck       <= 1'b0;
        end else if (terminal) begin
            phase_cnt <= '0;
            tck       <= ~tck;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R5
    tck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> run);

    // R5
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(tck)) |-> (phase_cnt == '0));

endmodule

// File: rtl/jid_capture.sv
module jid_capture #(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    input  logic            commit,
    output logic [ID_W-1:0] word,
    output logic            first_bit
);

    logic [ID_W-1:0] shadow;

    // First bit arrives first and ends up in position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (shift_en) begin
            shadow <= {bit_in, shadow[ID_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word      <= '0;
            first_bit <= 1'b0;
        end else if (commit) begin
            word      <= shadow;
            first_bit <= shadow[0];
        end
    end

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word) |-> $past(commit));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(first_bit) |-> $past(commit));

endmodule

// File: rtl/jid_tap_walker.sv
module jid_tap_walker
    import jid_pkg::*;
#(
    parameter int ID_W      = 32,
    parameter int RST_EDGES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rise_evt,
    input  logic fall_evt,
    output logic busy,
    output logic done,
    output logic tms,
    output logic shift_en,
    output logic commit
);

    localparam int CNT_W = (ID_W > RST_EDGES) ? $clog2(ID_W) : $clog2(RST_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_RST = CNT_W'(RST_EDGES - 1);

    walk_state_t state, nxt;
    logic [CNT_W-1:0] edge_cnt;
    logic             at_last_bit;

    assign at_last_bit = (edge_cnt == LAST_BIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_FORCE_RST;
            ST_FORCE_RST: if (rise_evt && edge_cnt == LAST_RST) nxt = ST_TLR;
            ST_TLR:       if (rise_evt) nxt = ST_RTI;
            ST_RTI:       if (rise_evt) nxt = ST_SEL_DR;
            ST_SEL_DR:    if (rise_evt) nxt = ST_CAP_DR;
            ST_CAP_DR:    if (rise_evt) nxt = ST_SHIFT_DR;
            ST_SHIFT_DR:  if (rise_evt && at_last_bit) nxt = ST_EXIT1_DR;
            ST_EXIT1_DR:  if (rise_evt) nxt = ST_UPDATE_DR;
            ST_UPDATE_DR: if (rise_evt) nxt = ST_PARK;
            ST_PARK:      if (fall_evt) nxt = ST_IDLE;
        endcase
    end

    // Edge counter for the reset run and the shift run
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state) begin
            edge_cnt <= '0;
        end else if (rise_evt && (state == ST_FORCE_RST || state == ST_SHIFT_DR)) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // Outputs
    assign busy     = (state != ST_IDLE);
    assign shift_en = rise_evt && (state == ST_SHIFT_DR);
    assign commit   = fall_evt && (state == ST_PARK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tms  <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= commit;
            if (state == ST_IDLE && start)
                tms <= 1'b1;
            else if (fall_evt)
                tms <= tms_for(state, at_last_bit);
        end
    end

    // R2
    reset_tms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TLR && $past(state) == ST_FORCE_RST) |-> $past(tms));

    // R3
    enter_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT_DR && $past(state) == ST_CAP_DR) |-> !$past(tms));

    // R3
    leave_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT1_DR && $past(state) == ST_SHIFT_DR) |-> $past(tms));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !commit) |=> busy);

endmodule

// File: rtl/jtag_id_reader.sv
module jtag_id_reader #(
    parameter int ID_W      = 32,
    parameter int DIV_W     = 8,
    parameter int RST_EDGES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             done,
    output logic [ID_W-1:0]  id_word,
    output logic             idcode_valid,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo
);

    localparam logic FILL_LEVEL = 1'b1;

    logic [DIV_W-1:0] div_q;
    logic             rise_evt;
    logic             fall_evt;
    logic             shift_en;
    logic             commit;

    // Divide value is frozen for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (start && !busy) div_q <= div;
    end

    assign tdi = FILL_LEVEL;

    jid_tck_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_val  (div_q),
        .tck      (tck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    jid_tap_walker #(.ID_W(ID_W), .RST_EDGES(RST_EDGES)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .busy     (busy),
        .done     (done),
        .tms      (tms),
        .shift_en (shift_en),
        .commit   (commit)
    );

    jid_capture #(.ID_W(ID_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .bit_in    (tdo),
        .commit    (commit),
        .word      (id_word),
        .first_bit (idcode_valid)
    );

    // R4
    tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> !tck);

    // R5
    tck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R5
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));

endmodule

// File: tb/jtag_id_reader_test.sv
module jtag_id_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  div = 8'd0;
    logic        busy, done, idcode_valid, tck, tms, tdi;
    logic [31:0] id_word;
    logic        tdo = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    jtag_id_reader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div),
        .busy(busy), .done(done), .id_word(id_word), .idcode_valid(idcode_valid),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // Target TAP model state codes
    localparam int T_TLR = 0, T_RTI = 1, T_SELDR = 2, T_CAPDR = 3, T_SHDR = 4,
                   T_EX1DR = 5, T_PADR = 6, T_EX2DR = 7, T_UPDR = 8, T_SELIR = 9,
                   T_CAPIR = 10, T_SHIR = 11, T_EX1IR = 12, T_PAIR = 13,
                   T_EX2IR = 14, T_UPIR = 15;

    int          tap_st = T_TLR;
    bit          has_id = 1'b1;
    logic [31:0] model_id = 32'h0;
    logic [31:0] dr = 32'h0;

    int          rise_n = 0;
    logic [63:0] tms_log = 64'h0;
    int          rise_cyc [2];
    bit          tdi_bad = 1'b0;
    bit          tms_bad = 1'b0;
    logic        prev_tms = 1'b1;

    function automatic int tap_next(input int s, input logic m);
        int n;
        n = s;
        case (s)
            T_TLR:   n = m ? T_TLR   : T_RTI;
            T_RTI:   n = m ? T_SELDR : T_RTI;
            T_SELDR: n = m ? T_SELIR : T_CAPDR;
            T_CAPDR: n = m ? T_EX1DR : T_SHDR;
            T_SHDR:  n = m ? T_EX1DR : T_SHDR;
            T_EX1DR: n = m ? T_UPDR  : T_PADR;
            T_PADR:  n = m ? T_EX2DR : T_PADR;
            T_EX2DR: n = m ? T_UPDR  : T_SHDR;
            T_UPDR:  n = m ? T_SELDR : T_RTI;
            T_SELIR: n = m ? T_TLR   : T_CAPIR;
            T_CAPIR: n = m ? T_EX1IR : T_SHIR;
            T_SHIR:  n = m ? T_EX1IR : T_SHIR;
            T_EX1IR: n = m ? T_UPIR  : T_PAIR;
            T_PAIR:  n = m ? T_EX2IR : T_PAIR;
            T_EX2IR: n = m ? T_UPIR  : T_SHIR;
            default: n = m ? T_SELDR : T_RTI;
        endcase
        return n;
    endfunction

    always @(posedge clk) cyc++;

    always @(posedge tck) begin
        if (rise_n < 64) tms_log[rise_n] = tms;
        if (rise_n < 2) rise_cyc[rise_n] = cyc;
        rise_n++;
        if (tdi !== 1'b1) tdi_bad = 1'b1;
        if (tap_st == T_CAPDR) dr <= has_id ? model_id : 32'h0;
        else if (tap_st == T_SHDR) dr <= has_id ? {tdi, dr[31:1]} : {31'h0, tdi};
        tap_st <= tap_next(tap_st, tms);
    end

    always @(negedge tck) tdo <= dr[0];

    always @(negedge clk) begin
        if (rst_n && tms !== prev_tms && tck === 1'b1) tms_bad = 1'b1;
        prev_tms = tms;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_tms();
        logic [63:0] v;
        v = 64'h0;
        for (int i = 0; i < 5; i++) v[i] = 1'b1;
        v[6]  = 1'b1;
        v[40] = 1'b1;
        v[41] = 1'b1;
        return v;
    endfunction

    task automatic run_one(input int d, input bit hid, input logic [31:0] idv,
                           input int init_st, input int poke);
        int lat;
        int exp_lat;
        logic [31:0] exp_word;
        @(negedge clk);
        has_id = hid; model_id = idv; tap_st = init_st; dr = 32'h0;
        rise_n = 0; tms_log = 64'h0; tdi_bad = 0; tms_bad = 0;
        div = 8'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'h1);
        lat = 0;
        while (done !== 1'b1 && lat < 5000) begin
            if (lat == poke) begin start = 1'b1; div = 8'd9; end
            else begin start = 1'b0; div = 8'(d); end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        exp_lat  = 86 * (d + 1);
        exp_word = hid ? idv : 32'hFFFF_FFFE;
        check(lat == exp_lat, "R8 done latency", 64'(lat), 64'(exp_lat));
        check(busy === 1'b0, "R8 busy low with done", 64'(busy), 64'h0);
        check(id_word === exp_word, "R6 id_word", 64'(id_word), 64'(exp_word));
        check(idcode_valid === hid, "R7 idcode_valid", 64'(idcode_valid), 64'(hid));
        check(rise_n == 43, "R3 rising edge count", 64'(rise_n), 64'd43);
        check(tms_log === exp_tms(), "R3 tms sequence", tms_log, exp_tms());
        check(tms_log[4:0] === 5'h1F, "R2 five reset edges", 64'(tms_log[4:0]), 64'h1F);
        check(tap_st == T_RTI, "R3 target parked in RTI", 64'(tap_st), 64'(T_RTI));
        check(rise_cyc[1] - rise_cyc[0] == 2 * (d + 1), "R5 tck period",
              64'(rise_cyc[1] - rise_cyc[0]), 64'(2 * (d + 1)));
        check(!tdi_bad, "R10 tdi held high", 64'(tdi_bad), 64'h0);
        check(!tms_bad, "R4 tms changes with tck low", 64'(tms_bad), 64'h0);
        @(negedge clk);
        check(done === 1'b0, "R8 done single cycle", 64'(done), 64'h0);
        repeat (4 * (d + 1)) begin
            @(negedge clk);
            if (busy !== 1'b0 || tck !== 1'b0) begin
                check(1'b0, "R9 no restart after run", {62'h0, busy, tck}, 64'h0);
                break;
            end
        end
        check(tck === 1'b0, "R5 tck low when idle", 64'(tck), 64'h0);
    endtask

    localparam int NV = 4;
    localparam int          V_DIV [NV] = '{0, 2, 1, 3};
    localparam bit          V_HID [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [31:0] V_ID  [NV] = '{32'h4BA0_0477, 32'h1234_5678,
                                           32'h1BE1_3C2F, 32'h8000_0001};
    localparam int          V_ST  [NV] = '{T_SHIR, T_PADR, T_EX2IR, T_TLR};

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy", 64'(busy), 64'h0);
        check(done === 1'b0, "R1 done", 64'(done), 64'h0);
        check(tck === 1'b0, "R1 tck", 64'(tck), 64'h0);
        check(tms === 1'b1, "R1 tms", 64'(tms), 64'h1);
        check(id_word === 32'h0, "R1 id_word", 64'(id_word), 64'h0);
        check(idcode_valid === 1'b0, "R1 idcode_valid", 64'(idcode_valid), 64'h0);

        for (int v = 0; v < NV; v++)
            run_one(V_DIV[v], V_HID[v], V_ID[v], V_ST[v], -1);

        // R9 start while busy, also R5 div change mid-run
        run_one(1, 1'b1, 32'hDEAD_BEEF, T_UPIR, 60);
        run_one(0, 1'b0, 32'h0, T_SHDR, 85);
        run_one(2, 1'b1, 32'h0000_0003, T_RTI, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule